// File: doc/BRIEF.md
# UART Transmitter with Break Generation

This block serialises data words onto an asynchronous line. Each word is framed by a low start bit and a high stop bit. The payload is eight or nine bits, chosen by a word-length control. All line timing comes from an external bit-rate tick, and every bit lasts one tick period. A one-word holding buffer lets software queue the next word while the current one is on the line. A ready flag shows when that buffer can take a write.

A break request makes the line go low for a whole break character. There are two ways to ask for one. A short pulse asks for one break after the word in flight. A level held high asks for breaks back to back. The break is 10 or 11 low bit periods in normal mode. In LIN master mode it is 13 or 14, the longer value of each pair going with nine-bit words. After every break the line is held high for one bit period. A pending break goes out before a word waiting in the buffer.

An optional serial clock output toggles once per data bit while enabled. Outside the data bits it rests at a programmable level.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset, `tx_out` is 1, `tx_ready` is 1 and `ser_clk` is 0, with all controls at 0.
- R2: A frame is a start bit of 0, then 8 data bits (`word9`=0) or 9 data bits (`word9`=1) least significant first, then a stop bit of 1. In 8-bit mode `wr_data[8]` is not sent. `tx_out` changes only in the cycle after one in which `bit_tick` is 1.
- R3: A write (`wr_en`=1) is accepted only while `tx_ready` is 1. `tx_ready` then stays 0 until the buffered word starts its start bit. A write made while `tx_ready` is 0 is discarded and never sent.
- R4: A break holds `tx_out` at 0 for a number of bit periods set by the controls at its start: 10 (`lin_mode`=0,`word9`=0), 11 (0,1), 13 (1,0) or 14 (1,1).
- R5: A falling edge of `brk_req` arms exactly one break. It is sent at the next frame boundary, after the word in flight finishes. It goes out ahead of any word waiting in the buffer.
- R6: While `brk_req` is held at 1, breaks repeat at every boundary. Releasing it arms one further break.
- R7: Every break is followed by at least one bit period with `tx_out` at 1 before the next frame or break.
- R8: If `brk_req` falls in the same cycle as the tick that ends a stop bit, the break starts at that very boundary.
- R9: With `sclk_en`=0, `ser_clk` stays 0.
- R10: With `sclk_en`=1, `ser_clk` equals `sclk_idle_hi` outside data bits. During data bit i (counted from 0) it is inverted for even i and equals `sclk_idle_hi` for odd i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_en | input | 1 | Write strobe for a data word |
| wr_data | input | 9 | Data word; bit 8 is used only in 9-bit mode |
| word9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| lin_mode | input | 1 | 1 selects the longer LIN master break lengths |
| brk_req | input | 1 | Break request, pulse or level |
| sclk_en | input | 1 | Enables the serial clock output |
| sclk_idle_hi | input | 1 | Rest level of the serial clock |
| tx_out | output | 1 | Serial line, idles high |
| ser_clk | output | 1 | Serial clock output |
| tx_ready | output | 1 | 1 when the holding buffer can accept a write |

## Verification
Two events can land in the same cycle: the release of a break request and the tick that ends a stop bit, which is where the next break-or-word choice is made. The bench provokes this by clearing `brk_req` on exactly the cycle in which it raises `bit_tick` at the end of a frame. It then expects a break of the configured length to begin at that boundary and the line to go idle afterwards. A second collision, a buffered word waiting at the boundary where a pulsed break comes due, is judged by the break appearing first and the word following the guard period.

// File: rtl/uarttx_pkg.sv
package uarttx_pkg;

    localparam int WORD_MAX  = 9;
    localparam int BRK_BASE  = 10;
    localparam int LIN_EXTRA = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_BREAK,
        ST_GUARD
    } tx_state_e;

    function automatic int brk_bits(input logic lin, input logic w9);
        return BRK_BASE + (w9 ? 1 : 0) + (lin ? LIN_EXTRA : 0);
    endfunction

    function automatic int data_bits(input logic w9);
        return w9 ? WORD_MAX : WORD_MAX - 1;
    endfunction

endpackage

// File: rtl/txb_holdbuf.sv
module txb_holdbuf #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         vld,
    output logic [W-1:0] data
);
    logic         vld_q;
    logic [W-1:0] dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else if (push && !vld_q) begin
            vld_q <= 1'b1;
            dat_q <= push_data;
        end else if (pop) begin
            vld_q <= 1'b0;
        end
    end

    assign vld  = vld_q;
    assign data = dat_q;
endmodule

// File: rtl/txb_brkreq.sv
module txb_brkreq (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic take,
    output logic want
);
    logic prev_q;
    logic pend_q;
    logic fall;

    // a release seen this cycle counts at once, so a boundary on the same edge is not missed
    assign fall = prev_q && !req;
    assign want = req || pend_q || fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= req;
            if (take)
                pend_q <= 1'b0;
            else if (fall)
                pend_q <= 1'b1;
        end
    end
endmodule

// File: rtl/txb_serializer.sv
module txb_serializer
    import uarttx_pkg::*;
#(
    parameter int W = WORD_MAX
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         buf_vld,
    input  logic [W-1:0] buf_data,
    input  logic         word9,
    input  logic         lin,
    input  logic         brk_want,
    output logic         buf_pop,
    output logic         brk_take,
    output logic         tx,
    output tx_state_e    state,
    output logic [$clog2(W)-1:0] bit_idx
);
    localparam int BRK_MAX = brk_bits(1'b1, 1'b1);
    localparam int CNT_W   = $clog2(BRK_MAX);
    localparam int IDX_W   = $clog2(W);

    tx_state_e        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_q;
    logic [W-1:0]     sh_q;
    logic             boundary;

    assign boundary = (st_q == ST_IDLE) || (st_q == ST_STOP) || (st_q == ST_GUARD);
    assign brk_take = tick && boundary && brk_want;
    assign buf_pop  = tick && boundary && !brk_want && buf_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            idx_q  <= '0;
            last_q <= '0;
            sh_q   <= '0;
        end else if (tick) begin
            case (st_q)
                ST_IDLE, ST_STOP, ST_GUARD: begin
                    if (brk_want) begin
                        st_q  <= ST_BREAK;
                        cnt_q <= CNT_W'(brk_bits(lin, word9) - 1);
                    end else if (buf_vld) begin
                        st_q   <= ST_START;
                        sh_q   <= buf_data;
                        last_q <= IDX_W'(data_bits(word9) - 1);
                    end else begin
                        st_q <= ST_IDLE;
                    end
                end
                ST_START: begin
                    st_q  <= ST_DATA;
                    idx_q <= '0;
                end
                ST_DATA: begin
                    sh_q <= {1'b0, sh_q[W-1:1]};
                    if (idx_q == last_q)
                        st_q <= ST_STOP;
                    else
                        idx_q <= idx_q + 1'b1;
                end
                ST_BREAK: begin
                    if (cnt_q == '0)
                        st_q <= ST_GUARD;
                    else
                        cnt_q <= cnt_q - 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (st_q)
            ST_START, ST_BREAK: tx = 1'b0;
            ST_DATA:            tx = sh_q[0];
            default:            tx = 1'b1;
        endcase
    end

    assign state   = st_q;
    assign bit_idx = idx_q;
endmodule

// File: rtl/txb_clkgen.sv
module txb_clkgen
    import uarttx_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             en,
    input  logic             idle_hi,
    input  tx_state_e        state,
    input  logic [IDX_W-1:0] bit_idx,
    output logic             sclk
);
    logic active_half;

    assign active_half = (state == ST_DATA) && !bit_idx[0];
    assign sclk        = en && (idle_hi ^ active_half);
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
    import uarttx_pkg::*;
#(
    parameter int DATA_W = WORD_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              word9,
    input  logic              lin_mode,
    input  logic              brk_req,
    input  logic              sclk_en,
    input  logic              sclk_idle_hi,
    output logic              tx_out,
    output logic              ser_clk,
    output logic              tx_ready
);
    localparam int IDX_W = $clog2(DATA_W);

    logic              buf_vld;
    logic [DATA_W-1:0] buf_data;
    logic              buf_pop;
    logic              brk_want;
    logic              brk_take;
    tx_state_e         st_w;
    logic [IDX_W-1:0]  idx_w;

    txb_holdbuf #(.W(DATA_W)) i_buf (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (buf_pop),
        .vld       (buf_vld),
        .data      (buf_data)
    );

    txb_brkreq i_brk (
        .clk  (clk),
        .rst  (rst),
        .req  (brk_req),
        .take (brk_take),
        .want (brk_want)
    );

    txb_serializer #(.W(DATA_W)) i_ser (
        .clk      (clk),
        .rst      (rst),
        .tick     (bit_tick),
        .buf_vld  (buf_vld),
        .buf_data (buf_data),
        .word9    (word9),
        .lin      (lin_mode),
        .brk_want (brk_want),
        .buf_pop  (buf_pop),
        .brk_take (brk_take),
        .tx       (tx_out),
        .state    (st_w),
        .bit_idx  (idx_w)
    );

    txb_clkgen #(.IDX_W(IDX_W)) i_clk (
        .en      (sclk_en),
        .idle_hi (sclk_idle_hi),
        .state   (st_w),
        .bit_idx (idx_w),
        .sclk    (ser_clk)
    );

    assign tx_ready = !buf_vld;
endmodule

// File: rtl/uart_brk_tx_chk.sv
module uart_brk_tx_chk
    import uarttx_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      bit_tick,
    input logic      wr_en,
    input logic      sclk_en,
    input logic      sclk_idle_hi,
    input logic      tx_out,
    input logic      ser_clk,
    input logic      tx_ready,
    input tx_state_e st
);
    localparam int BRK_MAX = brk_bits(1'b1, 1'b1);

    logic [4:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)
            low_run <= '0;
        else if (bit_tick)
            low_run <= tx_out ? 5'd0 : ((low_run == 5'd31) ? low_run : low_run + 5'd1);
    end

    // R2
    tx_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(tx_out));

    // R3
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && tx_ready |=> !tx_ready);

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_ready && !bit_tick |=> !tx_ready);

    // R4
    low_run_chk: assert property (@(posedge clk) disable iff (rst)
        low_run <= 5'(BRK_MAX));

    // R7
    guard_high_chk: assert property (@(posedge clk) disable iff (rst)
        st == ST_GUARD |-> tx_out);

    // R9
    sclk_off_chk: assert property (@(posedge clk) disable iff (rst)
        !sclk_en |-> !ser_clk);

    // R10
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        sclk_en && st != ST_DATA |-> ser_clk == sclk_idle_hi);
endmodule

bind uart_brk_tx uart_brk_tx_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .bit_tick     (bit_tick),
    .wr_en        (wr_en),
    .sclk_en      (sclk_en),
    .sclk_idle_hi (sclk_idle_hi),
    .tx_out       (tx_out),
    .ser_clk      (ser_clk),
    .tx_ready     (tx_ready),
    .st           (st_w)
);

// File: tb/test_uart_brk_tx.sv
`timescale 1ns/1ps
module test_uart_brk_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       word9 = 1'b0;
    logic       lin_mode = 1'b0;
    logic       brk_req = 1'b0;
    logic       sclk_en = 1'b0;
    logic       sclk_idle_hi = 1'b0;
    logic       tx_out, ser_clk, tx_ready;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;

    uart_brk_tx i_uart_brk_tx (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .wr_en(wr_en), .wr_data(wr_data),
        .word9(word9), .lin_mode(lin_mode), .brk_req(brk_req), .sclk_en(sclk_en),
        .sclk_idle_hi(sclk_idle_hi), .tx_out(tx_out), .ser_clk(ser_clk), .tx_ready(tx_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // one bit period of four cycles; the tick is raised in the first cycle
    task automatic bp(input bit clr, output logic t, output logic s);
        @(negedge clk);
        bit_tick = 1'b1;
        if (clr) brk_req = 1'b0;
        @(negedge clk);
        bit_tick = 1'b0;
        t = tx_out;
        s = ser_clk;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [8:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_brk();
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
        @(negedge clk);
    endtask

    // mode 1: queue d2 and pulse a break; mode 2: raise brk_req; mode 3: queue d2 then try ~d2
    task automatic frame(input logic [8:0] d, input int n, input int mode,
                         input logic [8:0] d2, input bit fresh);
        logic [11:0] got_tx, exp_tx, got_ck, exp_ck;
        logic t, s;
        got_tx = '0; exp_tx = '0; got_ck = '0; exp_ck = '0;
        if (fresh) begin
            wr(d);
            chk(tx_ready == 1'b0, "R3 ready after write", int'(tx_ready), 0);
        end
        for (int i = 0; i < n + 2; i++) begin
            bp(1'b0, t, s);
            got_tx[i] = t;
            got_ck[i] = s;
            exp_tx[i] = (i == 0) ? 1'b0 : (i == n + 1) ? 1'b1 : d[i-1];
            exp_ck[i] = sclk_en & (sclk_idle_hi ^ ((i >= 1) && (i <= n) && ((i - 1) % 2 == 0)));
            if (i == 0 && fresh)
                chk(tx_ready == 1'b1, "R3 ready at start bit", int'(tx_ready), 1);
            if (i == 3) begin
                case (mode)
                    1: begin wr(d2); pulse_brk(); end
                    2: brk_req = 1'b1;
                    3: begin
                        wr(d2);
                        chk(tx_ready == 1'b0, "R3 buffer full", int'(tx_ready), 0);
                        wr(~d2);
                        chk(tx_ready == 1'b0, "R3 full after ignored write", int'(tx_ready), 0);
                    end
                    default: ;
                endcase
            end
        end
        chk(got_tx == exp_tx, "R2 frame bits", int'(got_tx), int'(exp_tx));
        chk(got_ck == exp_ck, sclk_en ? "R10 serial clock" : "R9 serial clock off",
            int'(got_ck), int'(exp_ck));
    endtask

    task automatic expect_brk(input int len, input bit clr_first, input string tag);
        int lows;
        logic t, s;
        lows = 0;
        for (int i = 0; i < len; i++) begin
            bp(clr_first && (i == 0), t, s);
            if (!t) lows++;
        end
        chk(lows == len, tag, lows, len);
        bp(1'b0, t, s);
        chk(t == 1'b1, "R7 guard high", int'(t), 1);
    endtask

    task automatic expect_idle(input string tag);
        logic t, s;
        bp(1'b0, t, s);
        chk(t == 1'b1, tag, int'(t), 1);
    endtask

    initial begin
        #(5ns * 190000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic t, s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(tx_out == 1'b1, "R1 tx idle", int'(tx_out), 1);
        chk(tx_ready == 1'b1, "R1 ready", int'(tx_ready), 1);
        chk(ser_clk == 1'b0, "R1 serial clock", int'(ser_clk), 0);

        // R2 / R10 sweep: every 8-bit and every 9-bit value
        sclk_en = 1'b1;
        for (int w = 0; w < 2; w++) begin
            word9 = w[0];
            for (int v = 0; v < (w ? 512 : 256); v++) begin
                logic [8:0] d;
                d = w ? 9'(v) : {~v[0], v[7:0]};
                sclk_idle_hi = d[1];
                frame(d, w ? 9 : 8, 0, 9'h0, 1'b1);
            end
        end
        expect_idle("R2 idle after frames");

        // R9: clock disabled with high rest level
        sclk_en = 1'b0; sclk_idle_hi = 1'b1; word9 = 1'b0;
        frame(9'h0A5, 8, 0, 9'h0, 1'b1);
        sclk_en = 1'b1;

        // R4: all four break lengths from idle
        for (int l = 0; l < 2; l++) begin
            for (int w = 0; w < 2; w++) begin
                lin_mode = l[0]; word9 = w[0];
                pulse_brk();
                expect_brk(10 + w + 3 * l, 1'b0, "R4 break length");
                expect_idle("R5 single break per pulse");
            end
        end

        // R5: pulse during a word, with a word buffered behind it
        lin_mode = 1'b1; word9 = 1'b0;
        frame(9'h03C, 8, 1, 9'h0C3, 1'b1);
        expect_brk(13, 1'b0, "R5 break before buffered word");
        frame(9'h0C3, 8, 0, 9'h0, 1'b0);
        expect_idle("R5 idle after buffered word");

        // R6: held request repeats, release adds one more
        lin_mode = 1'b0; word9 = 1'b1;
        brk_req = 1'b1;
        expect_brk(11, 1'b0, "R6 first held break");
        begin
            int lows;
            lows = 0;
            for (int i = 0; i < 11; i++) begin
                bp(1'b0, t, s);
                if (!t) lows++;
                if (i == 5) brk_req = 1'b0;
            end
            chk(lows == 11, "R6 second held break", lows, 11);
            bp(1'b0, t, s);
            chk(t == 1'b1, "R7 guard between breaks", int'(t), 1);
        end
        expect_brk(11, 1'b0, "R6 break after release");
        expect_idle("R6 idle after release break");

        // R8: release on the tick that ends the stop bit
        lin_mode = 1'b0; word9 = 1'b0;
        frame(9'h05A, 8, 2, 9'h0, 1'b1);
        expect_brk(10, 1'b1, "R8 coincident release");
        expect_idle("R8 single break");

        // R3: write while full is discarded
        frame(9'h111, 8, 3, 9'h0E7, 1'b1);
        frame(9'h0E7, 8, 0, 9'h0, 1'b0);
        expect_idle("R3 discarded word not sent");
        expect_idle("R3 line stays idle");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule